// File: doc/BRIEF.md
# Keyboard Controller Output Status Logic

This block is the output half of a legacy keyboard-controller host interface. A local microcontroller writes the output data register through one of two addresses: a keyboard address or an auxiliary (mouse) address. Each write sets the host status register's output-buffer-full bit (D0). A write through the auxiliary address also sets the auxiliary-output bit (D5). The block drives the keyboard and mouse interrupt lines from these flags. When the host reads its data port, the flags are cleared.

Three mode inputs shape the behaviour. The first is a global interrupt enable. The second selects the keyboard interrupt source: either a flag that tracks writes automatically, or a latch that firmware writes directly. The third decides whether D5 follows auxiliary writes in hardware or is a bit that firmware owns. The block also returns an interrupt-source readback byte to the microcontroller.

Top module: `kbc_obf_status`

## Requirements
- R1: After the asynchronous reset, every flag is 0, and so are the firmware latch and the user D5 bit. This makes all outputs 0.
- R2: While `obf_en_i` is 0, `kbd_irq_o` and `mouse_irq_o` are 0 whatever the writes.
- R3: A write to the keyboard address (default 0x7FF1) sets `obf_o` and the write-tracked keyboard flag, and clears the auxiliary flag. With `aux_hw_i`=1, `status_aux_o` then reads 0.
- R4: A write to the auxiliary address (default 0x7FFA) sets `obf_o` and the auxiliary flag. With `obf_en_i`=1, `mouse_irq_o` is then 1, whatever `aux_hw_i` is.
- R5: With `obf_en_i`=1 and `fw_sel_i`=0, `kbd_irq_o` equals the write-tracked keyboard flag.
- R6: With `obf_en_i`=1 and `fw_sel_i`=1, `kbd_irq_o` equals the firmware latch. The latch is loaded from data bit 0 on a write to the latch address (default 0x7FFD) and keeps its value otherwise.
- R7: `uc_src_o` bit 0 carries the present keyboard interrupt source: the latch when `fw_sel_i`=1, else the tracked flag. Bits 7..1 read 0.
- R8: A `host_rd_i` pulse clears `obf_o`, the keyboard flag and the auxiliary flag by the next clock edge. The firmware latch is not affected.
- R9: If a keyboard or auxiliary write lands in the same cycle as `host_rd_i`, the write wins and its flags end up set.
- R10: With `aux_hw_i`=0, `status_aux_o` shows a user bit. That bit is loaded from data bit 5 on a write to the user address (default 0x7FF2). Auxiliary writes still drive `mouse_irq_o`.
- R11: Writes to any other address leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uc_wr_i | input | 1 | Microcontroller write strobe |
| uc_addr_i | input | 16 | Microcontroller write address |
| uc_wdata_i | input | 8 | Microcontroller write data |
| host_rd_i | input | 1 | Host read of the data port (one-cycle pulse) |
| obf_en_i | input | 1 | Interrupt output enable |
| fw_sel_i | input | 1 | Keyboard interrupt source: 1 = firmware latch, 0 = tracked flag |
| aux_hw_i | input | 1 | D5 control: 1 = hardware, 0 = user bit |
| obf_o | output | 1 | Status D0, output buffer full |
| status_aux_o | output | 1 | Status D5, auxiliary output full |
| kbd_irq_o | output | 1 | Keyboard interrupt |
| mouse_irq_o | output | 1 | Mouse interrupt |
| uc_src_o | output | 8 | Interrupt-source readback |

## Verification
The bench targets a keyboard write that collides with a host read. A design that gives the clear priority loses the byte, and D0 reads 0. It then switches the interrupt source to the firmware latch and issues host reads. A design that clears the latch on those reads drops the keyboard interrupt. Auxiliary writes are run in user-bit mode to show that D5 stays with firmware while the mouse interrupt still fires. A design that ties the mouse interrupt to D5 fails there. Writes to unused addresses and writes made with the enable low complete the picture; a loose decoder or a missing gate shows up as a spurious flag or interrupt.

// File: rtl/kbc_obf_pkg.sv
package kbc_obf_pkg;
  typedef struct packed {
    logic kbd;
    logic aux;
    logic latch;
    logic user;
  } wr_strobe_t;
endpackage

// File: rtl/kbc_obf_decode.sv
module kbc_obf_decode
  import kbc_obf_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KBD_ADDR   = 16'h7FF1,
  parameter logic [ADDR_W-1:0] AUX_ADDR   = 16'h7FFA,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'h7FFD,
  parameter logic [ADDR_W-1:0] USER_ADDR  = 16'h7FF2
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strobe_t        stb_o
);
  always_comb begin
    stb_o.kbd   = wr_i && (addr_i == KBD_ADDR);
    stb_o.aux   = wr_i && (addr_i == AUX_ADDR);
    stb_o.latch = wr_i && (addr_i == LATCH_ADDR);
    stb_o.user  = wr_i && (addr_i == USER_ADDR);
  end
endmodule

// File: rtl/kbc_obf_flags.sv
module kbc_obf_flags
  import kbc_obf_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LATCH_BIT = 0,
  parameter int unsigned USER_BIT  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_strobe_t        stb_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              host_rd_i,
  output logic              obf_o,
  output logic              kbd_flag_o,
  output logic              aux_flag_o,
  output logic              latch_o,
  output logic              user_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obf_o      <= 1'b0;
      kbd_flag_o <= 1'b0;
      aux_flag_o <= 1'b0;
    end else if (stb_i.kbd) begin
      obf_o      <= 1'b1;
      kbd_flag_o <= 1'b1;
      aux_flag_o <= 1'b0;
    end else if (stb_i.aux) begin
      obf_o      <= 1'b1;
      aux_flag_o <= 1'b1;
    end else if (host_rd_i) begin
      obf_o      <= 1'b0;
      kbd_flag_o <= 1'b0;
      aux_flag_o <= 1'b0;
    end
  end

  // firmware-owned bits, untouched by host reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= 1'b0;
      user_o  <= 1'b0;
    end else begin
      if (stb_i.latch) latch_o <= wdata_i[LATCH_BIT];
      if (stb_i.user)  user_o  <= wdata_i[USER_BIT];
    end
  end

  AST_KBD_WR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i.kbd |=> obf_o && kbd_flag_o && !aux_flag_o); // R3
  AST_AUX_WR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i.aux |=> obf_o && aux_flag_o); // R4
  AST_HOST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && !stb_i.kbd && !stb_i.aux |=> !obf_o && !kbd_flag_o && !aux_flag_o); // R8
  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && (stb_i.kbd || stb_i.aux) |=> obf_o); // R9
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i.latch |=> $stable(latch_o)); // R6
endmodule

// File: rtl/kbc_obf_irq.sv
module kbc_obf_irq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              obf_en_i,
  input  logic              fw_sel_i,
  input  logic              aux_hw_i,
  input  logic              kbd_flag_i,
  input  logic              aux_flag_i,
  input  logic              latch_i,
  input  logic              user_i,
  output logic              status_aux_o,
  output logic              kbd_irq_o,
  output logic              mouse_irq_o,
  output logic [DATA_W-1:0] src_o
);
  logic kbd_src;

  always_comb begin
    kbd_src      = fw_sel_i ? latch_i : kbd_flag_i;
    status_aux_o = aux_hw_i ? aux_flag_i : user_i;
    kbd_irq_o    = obf_en_i && kbd_src;
    mouse_irq_o  = obf_en_i && aux_flag_i;
    src_o        = '0;
    src_o[0]     = kbd_src;
  end
endmodule

// File: rtl/kbc_obf_status.sv
module kbc_obf_status
  import kbc_obf_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KBD_ADDR   = 16'h7FF1,
  parameter logic [ADDR_W-1:0] AUX_ADDR   = 16'h7FFA,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'h7FFD,
  parameter logic [ADDR_W-1:0] USER_ADDR  = 16'h7FF2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uc_wr_i,
  input  logic [ADDR_W-1:0] uc_addr_i,
  input  logic [DATA_W-1:0] uc_wdata_i,
  input  logic              host_rd_i,
  input  logic              obf_en_i,
  input  logic              fw_sel_i,
  input  logic              aux_hw_i,
  output logic              obf_o,
  output logic              status_aux_o,
  output logic              kbd_irq_o,
  output logic              mouse_irq_o,
  output logic [DATA_W-1:0] uc_src_o
);
  localparam int unsigned LATCH_BIT = 0;
  localparam int unsigned USER_BIT  = (DATA_W > 5) ? 5 : DATA_W - 1;

  wr_strobe_t stb;
  logic kbd_flag, aux_flag, latch_q, user_q;

  kbc_obf_decode #(
    .ADDR_W(ADDR_W), .KBD_ADDR(KBD_ADDR), .AUX_ADDR(AUX_ADDR),
    .LATCH_ADDR(LATCH_ADDR), .USER_ADDR(USER_ADDR)
  ) u_decode (
    .wr_i(uc_wr_i), .addr_i(uc_addr_i), .stb_o(stb)
  );

  kbc_obf_flags #(
    .DATA_W(DATA_W), .LATCH_BIT(LATCH_BIT), .USER_BIT(USER_BIT)
  ) u_flags (
    .clk_i, .rst_ni, .stb_i(stb), .wdata_i(uc_wdata_i), .host_rd_i,
    .obf_o, .kbd_flag_o(kbd_flag), .aux_flag_o(aux_flag),
    .latch_o(latch_q), .user_o(user_q)
  );

  kbc_obf_irq #(.DATA_W(DATA_W)) u_irq (
    .obf_en_i, .fw_sel_i, .aux_hw_i,
    .kbd_flag_i(kbd_flag), .aux_flag_i(aux_flag),
    .latch_i(latch_q), .user_i(user_q),
    .status_aux_o, .kbd_irq_o, .mouse_irq_o, .src_o(uc_src_o)
  );

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !obf_en_i |-> !kbd_irq_o && !mouse_irq_o); // R2
  AST_KIRQ_MATCHES_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obf_en_i |-> kbd_irq_o == uc_src_o[0]); // R7
  AST_MIRQ_NEEDS_OBF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mouse_irq_o |-> obf_o); // R4
  AST_OTHER_ADDR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb.kbd && !stb.aux && !host_rd_i |=> obf_o == $past(obf_o)); // R11
endmodule

// File: tb/kbc_obf_status_tb.sv
module kbc_obf_status_tb_top;
  localparam logic [15:0] A_KBD = 16'h7FF1, A_AUX = 16'h7FFA,
                          A_LAT = 16'h7FFD, A_USR = 16'h7FF2;

  logic clk = 0, rst_n = 0;
  logic wr = 0, hrd = 0, oen = 0, fsel = 0, auxhw = 1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic obf, d5, kirq, mirq;
  logic [7:0] src;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit m_obf, m_kbd, m_aux, m_lat, m_usr;

  always #5 clk = ~clk;

  kbc_obf_status dut_i (
    .clk_i(clk), .rst_ni(rst_n), .uc_wr_i(wr), .uc_addr_i(addr),
    .uc_wdata_i(wdata), .host_rd_i(hrd), .obf_en_i(oen), .fw_sel_i(fsel),
    .aux_hw_i(auxhw), .obf_o(obf), .status_aux_o(d5), .kbd_irq_o(kirq),
    .mouse_irq_o(mirq), .uc_src_o(src)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_obf = 0; m_kbd = 0; m_aux = 0; m_lat = 0; m_usr = 0;
    end else begin
      bit kw, aw;
      kw = wr && addr == A_KBD;
      aw = wr && addr == A_AUX;
      if (hrd) begin m_obf = 0; m_kbd = 0; m_aux = 0; end
      if (kw) begin m_obf = 1; m_kbd = 1; m_aux = 0; end
      if (aw) begin m_obf = 1; m_aux = 1; end
      if (wr && addr == A_LAT) m_lat = wdata[0];
      if (wr && addr == A_USR) m_usr = wdata[5];
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    bit s;
    s = fsel ? m_lat : m_kbd;
    chk("R8 obf",  {7'b0, obf},  {7'b0, m_obf});
    chk("R10 d5",  {7'b0, d5},   {7'b0, auxhw ? m_aux : m_usr});
    chk("R5 kirq", {7'b0, kirq}, {7'b0, oen & s});
    chk("R4 mirq", {7'b0, mirq}, {7'b0, oen & m_aux});
    chk("R7 src",  src,          {7'b0, s});
  end

  task automatic cyc(input logic w, input logic [15:0] a, input logic [7:0] d, input logic r);
    @(posedge clk); #1;
    wr = w; addr = a; wdata = d; hrd = r;
    @(posedge clk); #1;
    wr = 0; hrd = 0; addr = '0; wdata = '0;
    @(negedge clk); #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset obf", {7'b0, obf}, 8'h0);
    chk("R1 reset irq", {6'b0, kirq, mirq}, 8'h0);
    chk("R1 reset src", src, 8'h0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk); #1;
    chk("R1 after release", {4'b0, obf, d5, kirq, mirq}, 8'h0);

    // enable low: writes set status but no interrupts
    cyc(1, A_KBD, 8'h11, 0);
    cyc(1, A_AUX, 8'h22, 0);
    chk("R2 kirq gated", {7'b0, kirq}, 8'h0);
    chk("R2 mirq gated", {7'b0, mirq}, 8'h0);
    chk("R4 aux sets obf", {6'b0, obf, d5}, 8'h3);
    cyc(0, '0, '0, 1);

    oen = 1;
    cyc(1, A_KBD, 8'h5A, 0);
    chk("R5 kirq from flag", {7'b0, kirq}, 8'h1);
    chk("R3 d5 stays 0", {6'b0, obf, d5}, 8'h2);
    cyc(0, '0, '0, 1);
    chk("R8 kirq falls", {6'b0, obf, kirq}, 8'h0);

    cyc(1, A_AUX, 8'h33, 0);
    chk("R4 mirq set", {5'b0, obf, d5, mirq}, 8'h7);
    cyc(1, A_KBD, 8'h44, 0);
    chk("R3 kbd clears d5", {6'b0, d5, mirq}, 8'h0);
    cyc(0, '0, '0, 1);

    fsel = 1;
    cyc(1, A_LAT, 8'h01, 0);
    chk("R6 kirq from latch", {7'b0, kirq}, 8'h1);
    chk("R7 src readback", src, 8'h01);
    cyc(0, '0, '0, 1);
    chk("R8 latch survives read", {7'b0, kirq}, 8'h1);
    cyc(1, A_LAT, 8'hFE, 0);
    chk("R6 latch cleared", {7'b0, kirq}, 8'h0);
    cyc(1, A_KBD, 8'h01, 0);
    chk("R6 flag ignored in latch mode", {7'b0, kirq}, 8'h0);
    cyc(0, '0, '0, 1);

    fsel = 0;
    cyc(1, A_AUX, 8'h55, 1);
    chk("R9 aux write beats read", {5'b0, obf, d5, mirq}, 8'h7);
    cyc(1, A_KBD, 8'h66, 1);
    chk("R9 kbd write beats read", {6'b0, obf, kirq}, 8'h3);
    cyc(0, '0, '0, 1);

    auxhw = 0;
    cyc(1, A_USR, 8'h20, 0);
    chk("R10 user bit set", {6'b0, d5, obf}, 8'h2);
    cyc(1, A_USR, 8'h00, 0);
    cyc(1, A_AUX, 8'h77, 0);
    chk("R10 d5 user, mirq hw", {6'b0, d5, mirq}, 8'h1);
    cyc(0, '0, '0, 1);

    cyc(1, 16'h7FF5, 8'hFF, 0);
    cyc(1, 16'h0060, 8'hFF, 0);
    chk("R11 other addr ignored", {4'b0, obf, d5, kirq, mirq}, 8'h0);
    chk("R11 src unchanged", src, 8'h0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule